// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

This block is a watchdog timer that sits on a simple register bus with a setup phase and an access phase. When enabled, one counter runs through two stages. In the first, the warning stage, it counts a selectable power-of-two number of ticks. At the end it sets a sticky expiry flag, which can drive an interrupt. The counter then enters the final stage and counts a second selectable power-of-two interval. When that interval ends, the block emits a fixed-length reset pulse and goes back to the warning stage. Software keeps the system alive by writing a restart key. The restart sends the counter back to the start of the warning stage.

Two registers are guarded: the control register and the restart register. A write to either takes effect only if the bus access just before it was a write of the unlock key. The unlock is single-use. Ticks come either from the bus clock or from rising edges of a slow external clock input. That input is synchronised and turned into a one-cycle enable inside the bus clock domain.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, the control register and the expiry flag are zero, and `irq_o` and `wdt_rst_o` are low. A read at offset 0x00 returns the parameter `ID_VALUE`, and writes to that offset have no effect.
- R2: A write to control (offset 0x10) or restart (offset 0x14) is accepted only if the previous bus access was a write of 0x00005AA5 to offset 0x18. Each such write, accepted or not, uses up the unlock.
- R3: Any bus access other than the guarded write clears a pending unlock. This covers reads, writes of any other value to 0x18, and writes to 0x00 or 0x1C.
- R4: The control fields are: bit 0 counter enable, bit 1 tick source (1 = bus clock, 0 = external), bit 2 interrupt enable, bit 3 reset enable, bits [7:4] warning code, bits [10:8] final code. A control read returns those 11 bits, with bits [31:11] reading zero.
- R5: The final stage lasts 2^(7+n) ticks for final code n. Warning code c gives an interval of 2^s ticks. For c from 0 to 2, s is 6+2c. For c from 3 to 7, s is 8+c. For c from 8 to 15, s is 2c+1.
- R6: When the warning interval ends, the expiry flag (bit 0 at offset 0x1C) is set. `irq_o` equals the flag ANDed with the interrupt enable. After enabling in bus-clock mode, `irq_o` rises exactly 2^s cycles after the edge that accepted the control write.
- R7: When the warning interval ends, the final stage starts from zero. When the final interval ends, `wdt_rst_o` goes high for `RST_PULSE_CYCLES` cycles if reset enable is set, and counting goes back to the warning stage. If reset enable is clear, no pulse occurs.
- R8: Writing 1 to bit 0 at offset 0x1C clears the expiry flag, and writing 0 leaves it set. A set caused by expiry in the same cycle takes priority over the clear.
- R9: An accepted write of 0x0000CAFE to the restart register clears the counter and returns it to the warning stage, without touching the expiry flag. An accepted write of any other value has no effect.
- R10: While the enable bit is clear, the counter holds at zero in the warning stage. Enabling again starts a full warning interval.
- R11: With the tick source bit clear, each rising edge of `ext_clk_i` advances the counter by one. The edge is seen after a `SYNC_STAGES`-flop synchroniser and an edge detector. Bus clock cycles do not count in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Select, high during setup and access phases |
| penable_i | input | 1 | Access phase marker |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address of the register |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data for the addressed register |
| ext_clk_i | input | 1 | Slow external clock, asynchronous to clk_i |
| irq_o | output | 1 | Warning interrupt, level |
| wdt_rst_o | output | 1 | System reset pulse, active high |

## Verification
The bound checker watches several rules on every cycle. It checks that the control register changes only after an unlocked control write, that a read always drops the unlock, and that the expiry flag falls only after a write of 1 to the status register. It also checks that a restart or a cleared enable leaves the counter at zero in the warning stage, that the flag rises only from a running warning stage, and that the reset pulse starts only from the final stage and never lasts longer than its set length. Exact interval lengths for several codes can only be shown by the bench's scenarios, as can the extra cycle a restart buys and the flag surviving a restart. The same holds for the return to the warning stage after a reset pulse, the reset enable suppressing the pulse, and counting on external edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned BUS_DW = 32;
    localparam int unsigned CTRL_W = 11;

    localparam logic [7:0] OFF_ID     = 8'h00;
    localparam logic [7:0] OFF_CTRL   = 8'h10;
    localparam logic [7:0] OFF_KICK   = 8'h14;
    localparam logic [7:0] OFF_UNLOCK = 8'h18;
    localparam logic [7:0] OFF_STAT   = 8'h1C;

    localparam logic [BUS_DW-1:0] KEY_UNLOCK = 32'h0000_5AA5;
    localparam logic [BUS_DW-1:0] KEY_KICK   = 32'h0000_CAFE;

    // Field order matters: software sees these bit positions.
    typedef struct packed {
        logic [2:0] final_code; // [10:8]
        logic [3:0] warn_code;  // [7:4]
        logic       rst_en;     // [3]
        logic       int_en;     // [2]
        logic       bus_clk;    // [1]
        logic       enable;     // [0]
    } ctrl_t;

    typedef enum logic {
        ST_WARN  = 1'b0,
        ST_FINAL = 1'b1
    } stage_e;

    // Exponent of the warning interval for a 4-bit code.
    function automatic logic [4:0] warn_shift(input logic [3:0] code);
        logic [4:0] c;
        c = {1'b0, code};
        if (code <= 4'd2)      return 5'd6 + (c << 1);
        else if (code <= 4'd7) return 5'd8 + c;
        else                   return (c << 1) + 5'd1;
    endfunction

    // Exponent of the final interval for a 3-bit code.
    function automatic logic [4:0] final_shift(input logic [2:0] code);
        return 5'd7 + {2'b00, code};
    endfunction

endpackage

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_clk_i,
    output logic tick_o
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = (sync_q.chain << 1) | SYNC_STAGES'(ext_clk_i);
        sync_d.last  = sync_q.chain[MSB];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign tick_o = sync_q.chain[MSB] & ~sync_q.last;

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 5,
    parameter logic [BUS_DW-1:0] ID_VALUE = 32'h0057_D0A1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic [BUS_DW-1:0] pwdata_i,
    input  logic              warn_expire_i,
    output logic [BUS_DW-1:0] prdata_o,
    output ctrl_t             ctrl_o,
    output logic              flag_o,
    output logic              kick_o
);
    localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(OFF_ID);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_KICK   = ADDR_W'(OFF_KICK);
    localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFF_UNLOCK);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);

    typedef struct packed {
        ctrl_t ctrl;
        logic  unlock;
        logic  flag;
    } regs_t;

    regs_t state_d, state_q;
    logic  acc, wr;

    always_comb begin
        state_d = state_q;
        kick_o  = 1'b0;
        acc     = psel_i & penable_i;
        wr      = acc & pwrite_i;

        if (acc) begin
            state_d.unlock = 1'b0;
            if (wr) begin
                if (paddr_i == A_UNLOCK) begin
                    state_d.unlock = (pwdata_i == KEY_UNLOCK);
                end else if (paddr_i == A_CTRL) begin
                    if (state_q.unlock) state_d.ctrl = ctrl_t'(pwdata_i[CTRL_W-1:0]);
                end else if (paddr_i == A_KICK) begin
                    kick_o = state_q.unlock && (pwdata_i == KEY_KICK);
                end else if (paddr_i == A_STAT) begin
                    if (pwdata_i[0]) state_d.flag = 1'b0;
                end
            end
        end

        if (warn_expire_i) state_d.flag = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    always_comb begin
        prdata_o = '0;
        if (paddr_i == A_ID)        prdata_o = ID_VALUE;
        else if (paddr_i == A_CTRL) prdata_o = {{(BUS_DW-CTRL_W){1'b0}}, state_q.ctrl};
        else if (paddr_i == A_STAT) prdata_o = {{(BUS_DW-1){1'b0}}, state_q.flag};
    end

    assign ctrl_o = state_q.ctrl;
    assign flag_o = state_q.flag;

endmodule

// File: rtl/wdog_stage_counter.sv
module wdog_stage_counter
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W        = 32,
    parameter int unsigned PULSE_CYCLES = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       enable_i,
    input  logic       rst_en_i,
    input  logic [3:0] warn_code_i,
    input  logic [2:0] final_code_i,
    input  logic       kick_i,
    output logic       warn_expire_o,
    output logic       wdt_rst_o
);
    localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);

    typedef struct packed {
        stage_e           stage;
        logic [CNT_W-1:0] cnt;
        logic [PW-1:0]    pulse;
    } cnt_t;

    cnt_t             cnt_d, cnt_q;
    logic [CNT_W-1:0] warn_last, final_last, limit;
    logic             at_end;

    always_comb begin
        warn_last     = (CNT_W'(1) << warn_shift(warn_code_i)) - CNT_W'(1);
        final_last    = (CNT_W'(1) << final_shift(final_code_i)) - CNT_W'(1);
        limit         = (cnt_q.stage == ST_WARN) ? warn_last : final_last;
        at_end        = (cnt_q.cnt >= limit);

        cnt_d         = cnt_q;
        warn_expire_o = 1'b0;

        if (cnt_q.pulse != '0) cnt_d.pulse = cnt_q.pulse - 1'b1;

        if (!enable_i || kick_i) begin
            cnt_d.cnt   = '0;
            cnt_d.stage = ST_WARN;
        end else if (tick_i) begin
            if (at_end) begin
                cnt_d.cnt = '0;
                if (cnt_q.stage == ST_WARN) begin
                    warn_expire_o = 1'b1;
                    cnt_d.stage   = ST_FINAL;
                end else begin
                    cnt_d.stage = ST_WARN;
                    if (rst_en_i) cnt_d.pulse = PW'(PULSE_CYCLES);
                end
            end else begin
                cnt_d.cnt = cnt_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '{stage: ST_WARN, cnt: '0, pulse: '0};
        else         cnt_q <= cnt_d;
    end

    assign wdt_rst_o = (cnt_q.pulse != '0);

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
    import wdog_pkg::*;
#(
    parameter int unsigned       ADDR_W           = 5,
    parameter int unsigned       CNT_W            = 32,
    parameter int unsigned       SYNC_STAGES      = 2,
    parameter int unsigned       RST_PULSE_CYCLES = 4,
    parameter logic [BUS_DW-1:0] ID_VALUE         = 32'h0057_D0A1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic [31:0]       pwdata_i,
    output logic [31:0]       prdata_o,
    input  logic              ext_clk_i,
    output logic              irq_o,
    output logic              wdt_rst_o
);
    ctrl_t ctrl;
    logic  flag, kick, warn_expire, ext_tick, tick;

    wdog_regs #(
        .ADDR_W   (ADDR_W),
        .ID_VALUE (ID_VALUE)
    ) u_regs (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .psel_i        (psel_i),
        .penable_i     (penable_i),
        .pwrite_i      (pwrite_i),
        .paddr_i       (paddr_i),
        .pwdata_i      (pwdata_i),
        .warn_expire_i (warn_expire),
        .prdata_o      (prdata_o),
        .ctrl_o        (ctrl),
        .flag_o        (flag),
        .kick_o        (kick)
    );

    wdog_tick_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ext_clk_i (ext_clk_i),
        .tick_o    (ext_tick)
    );

    assign tick = ctrl.bus_clk ? 1'b1 : ext_tick;

    wdog_stage_counter #(
        .CNT_W        (CNT_W),
        .PULSE_CYCLES (RST_PULSE_CYCLES)
    ) u_cnt (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .tick_i        (tick),
        .enable_i      (ctrl.enable),
        .rst_en_i      (ctrl.rst_en),
        .warn_code_i   (ctrl.warn_code),
        .final_code_i  (ctrl.final_code),
        .kick_i        (kick),
        .warn_expire_o (warn_expire),
        .wdt_rst_o     (wdt_rst_o)
    );

    assign irq_o = flag & ctrl.int_en;

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W       = 5,
    parameter int unsigned CNT_W        = 32,
    parameter int unsigned PULSE_CYCLES = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              psel_i,
    input logic              penable_i,
    input logic              pwrite_i,
    input logic [ADDR_W-1:0] paddr_i,
    input logic              wdat0_i,
    input ctrl_t             ctrl_i,
    input logic              unlock_i,
    input logic              flag_i,
    input logic              kick_i,
    input stage_e            stage_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic              wdt_rst_i
);
    int unsigned hi_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        hi_run <= 0;
        else if (wdt_rst_i) hi_run <= hi_run + 1;
        else                hi_run <= 0;
    end

    // R2: control only changes after an unlocked control write
    a_r2_ctrl_guarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ctrl_i) |-> $past(psel_i && penable_i && pwrite_i &&
                                   paddr_i == ADDR_W'(OFF_CTRL) && unlock_i));

    // R3: a read always drops the unlock
    a_r3_read_relocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (psel_i && penable_i && !pwrite_i) |=> !unlock_i);

    // R6: the flag rises only out of a running warning stage
    a_r6_flag_from_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_i) |-> $past(stage_i == ST_WARN && ctrl_i.enable));

    // R7: a reset pulse starts only from the final stage with reset enabled
    a_r7_rst_from_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdt_rst_i) |-> $past(stage_i == ST_FINAL && ctrl_i.rst_en));

    // R7: the reset pulse never exceeds its set length
    a_r7_rst_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_rst_i |-> (hi_run < PULSE_CYCLES));

    // R8: the flag falls only after a write of 1 to status
    a_r8_flag_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag_i) |-> $past(psel_i && penable_i && pwrite_i &&
                                paddr_i == ADDR_W'(OFF_STAT) && wdat0_i));

    // R9: a restart leaves the counter at zero in the warning stage
    a_r9_kick_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick_i |=> (cnt_i == '0 && stage_i == ST_WARN));

    // R10: with enable clear the counter holds at zero
    a_r10_off_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_i.enable |=> (cnt_i == '0 && stage_i == ST_WARN));

endmodule

bind wdog_twostage wdog_checker #(
    .ADDR_W       (ADDR_W),
    .CNT_W        (CNT_W),
    .PULSE_CYCLES (RST_PULSE_CYCLES)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .wdat0_i   (pwdata_i[0]),
    .ctrl_i    (ctrl),
    .unlock_i  (u_regs.state_q.unlock),
    .flag_i    (flag),
    .kick_i    (kick),
    .stage_i   (u_cnt.cnt_q.stage),
    .cnt_i     (u_cnt.cnt_q.cnt),
    .wdt_rst_i (wdt_rst_o)
);

// File: tb/wdog_twostage_tb_top.sv
module wdog_twostage_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 5;
    localparam logic [31:0] ID_V = 32'h0057_D0A1;

    localparam logic [AW-1:0] A_ID = 5'h00, A_CTRL = 5'h10, A_KICK = 5'h14,
                              A_UNL = 5'h18, A_STAT = 5'h1C;

    logic clk = 1'b0, rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0, ext_clk = 0;
    logic [AW-1:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic irq, wrst;

    int cyc = 0, n_checks = 0, n_fail = 0;

    typedef struct {
        int    due;
        bit    sel_rst;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_twostage #(.ADDR_W(AW), .ID_VALUE(ID_V)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
        .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
        .ext_clk_i(ext_clk), .irq_o(irq), .wdt_rst_o(wrst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: pops expected output values when their cycle arrives.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                chk(sb[i].tag, {31'b0, sb[i].sel_rst ? wrst : irq}, {31'b0, sb[i].val});
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(input int off, input bit sel_rst, input logic v, input string tag);
        sb.push_back('{cyc + off, sel_rst, v, tag});
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        r = prdata;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        logic [31:0] r;
        bus(1'b1, a, d, r);
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] r;
        bus(1'b0, a, 32'h0, r);
        chk(tag, r, exp);
    endtask

    task automatic pwr(input logic [AW-1:0] a, input logic [31:0] d);
        wr(A_UNL, 32'h0000_5AA5);
        wr(a, d);
    endtask

    task automatic quiesce();
        pwr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h1);
    endtask

    task automatic ext_edge();
        @(negedge clk); ext_clk = 1;
        idle(4);
        ext_clk = 0;
        idle(4);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        int w0;
        idle(5);
        rst_n = 1;
        idle(2);

        // R1: reset state and identity register
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 rst after reset", {31'b0, wrst}, 32'h0);
        rd_chk(A_CTRL, 32'h0, "R1 ctrl after reset");
        rd_chk(A_STAT, 32'h0, "R1 status after reset");
        wr(A_ID, 32'hFFFF_FFFF);
        rd_chk(A_ID, ID_V, "R1 id constant after write");

        // R2: guarded writes
        wr(A_CTRL, 32'h7F6);
        rd_chk(A_CTRL, 32'h0, "R2 ctrl write without unlock");
        pwr(A_CTRL, 32'h7F6);
        rd_chk(A_CTRL, 32'h7F6, "R2 ctrl write with unlock");
        wr(A_CTRL, 32'h0);
        rd_chk(A_CTRL, 32'h7F6, "R2 unlock used once");

        // R3: other accesses clear the unlock
        wr(A_UNL, 32'h5AA5); rd_chk(A_STAT, 32'h0, "R3 status read");
        wr(A_CTRL, 32'h0);
        rd_chk(A_CTRL, 32'h7F6, "R3 read drops unlock");
        wr(A_UNL, 32'h5AA5); wr(A_UNL, 32'h1234); wr(A_CTRL, 32'h0);
        rd_chk(A_CTRL, 32'h7F6, "R3 wrong key drops unlock");
        wr(A_UNL, 32'h5AA5); wr(A_STAT, 32'h0); wr(A_CTRL, 32'h0);
        rd_chk(A_CTRL, 32'h7F6, "R3 status write drops unlock");

        // R4: field width
        pwr(A_CTRL, 32'hFFFF_F7F4);
        rd_chk(A_CTRL, 32'h7F4, "R4 upper control bits read zero");
        quiesce();

        // R6 R7: both stages at code 0, bus clock
        pwr(A_CTRL, 32'h00F);
        expect_at(63, 0, 0, "R6 irq before 2^6");
        expect_at(64, 0, 1, "R6 irq at 2^6");
        expect_at(191, 1, 0, "R7 rst before final end");
        expect_at(192, 1, 1, "R7 rst at final end");
        expect_at(195, 1, 1, "R7 rst pulse last cycle");
        expect_at(196, 1, 0, "R7 rst pulse ended");
        expect_at(383, 1, 0, "R7 back to warn stage, no early pulse");
        expect_at(384, 1, 1, "R7 second pulse after full warn+final");
        drain();
        idle(6);

        // R8: write-one-to-clear
        pwr(A_CTRL, 32'h00E);
        wr(A_STAT, 32'h0);
        chk("R8 write 0 keeps flag", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h1);
        chk("R8 write 1 clears flag", {31'b0, irq}, 32'h0);
        quiesce();

        // R9: restart key
        pwr(A_CTRL, 32'h00F);
        w0 = cyc;
        idle(10);
        pwr(A_KICK, 32'h1234);
        idle(20);
        pwr(A_KICK, 32'hCAFE);
        expect_at(w0 + 64 - cyc, 0, 0, "R9 restart pushed out expiry");
        expect_at(63, 0, 0, "R9 irq before new interval");
        expect_at(64, 0, 1, "R9 irq one interval after restart");
        drain();
        w0 = cyc - 1;
        idle(2);
        pwr(A_KICK, 32'hCAFE);
        expect_at(1, 0, 1, "R9 restart keeps flag");
        expect_at(w0 + 128 - cyc, 1, 0, "R9 old final end passes quietly");
        expect_at(191, 1, 0, "R9 no pulse before restarted end");
        expect_at(192, 1, 1, "R9 pulse at restarted end");
        drain();
        idle(6);
        quiesce();

        // R10: disable stops and clears
        pwr(A_CTRL, 32'h00F);
        idle(30);
        pwr(A_CTRL, 32'h00E);
        expect_at(80, 0, 0, "R10 no irq while disabled");
        expect_at(200, 1, 0, "R10 no rst while disabled");
        drain();
        pwr(A_CTRL, 32'h00F);
        expect_at(63, 0, 0, "R10 full interval after re-enable");
        expect_at(64, 0, 1, "R10 irq after re-enable");
        drain();
        quiesce();

        // R6 R7: enables masked
        pwr(A_CTRL, 32'h003);
        expect_at(65, 0, 0, "R6 irq masked");
        expect_at(192, 1, 0, "R7 no pulse without reset enable");
        expect_at(193, 1, 0, "R7 no pulse without reset enable late");
        drain();
        rd_chk(A_STAT, 32'h1, "R6 flag set while masked");
        pwr(A_CTRL, 32'h007);
        expect_at(1, 0, 1, "R6 irq follows enable of set flag");
        drain();
        quiesce();

        // R5: other encodings
        pwr(A_CTRL, 32'h32F);
        expect_at(1023, 0, 0, "R5 warn code 2 before 2^10");
        expect_at(1024, 0, 1, "R5 warn code 2 at 2^10");
        expect_at(2047, 1, 0, "R5 final code 3 before 2^10");
        expect_at(2048, 1, 1, "R5 final code 3 at 2^10");
        drain();
        idle(6);
        quiesce();
        pwr(A_CTRL, 32'h03F);
        expect_at(2047, 0, 0, "R5 warn code 3 before 2^11");
        expect_at(2048, 0, 1, "R5 warn code 3 at 2^11");
        expect_at(2175, 1, 0, "R5 final code 0 before 2^7");
        expect_at(2176, 1, 1, "R5 final code 0 at 2^7");
        drain();
        idle(6);
        quiesce();

        // R11: external tick source
        pwr(A_CTRL, 32'h005);
        for (int k = 0; k < 63; k++) ext_edge();
        chk("R11 63 edges, bus cycles ignored", {31'b0, irq}, 32'h0);
        ext_edge();
        chk("R11 irq on 64th edge", {31'b0, irq}, 32'h1);
        quiesce();

        idle(4);
        finish_run();
    end

endmodule